// File: doc/BRIEF.md
# Bidirectional Gate-Scan Shift Register

This block is the logic core of an active-matrix display row driver. A chain of 263 one-bit stages carries a start pulse down the panel, one row per rising edge of the scan clock, and each stage drives one row-select output. Several drivers can be chained: the pulse leaving the far end of one chain is handed to the next chip through a cascade output.

The scan direction is set by a direction input. It picks which of the two end pins takes in the start pulse and which one drives the cascade pulse out. Each end pin is modelled as a separate input, output and output-enable, so a pad ring can build the bidirectional pin. A mode input shortens the chain to 256 active rows by skipping a fixed band of seven middle rows (129 to 135). A blanking input forces every row output inactive without stopping the shifting. The cascade output is retimed to the falling edge of the clock. This gives the next chip half a period of setup before its own rising edge.

Top module: `gate_scan_chain`

## Requirements
- R1: While `rst` is high at a rising edge, every stage clears. All `row_o` bits are 0 after that edge, and the cascade output is 0 after the following falling edge.
- R2: With `dir_up`=1, a 1 on `lo_pin_i` at a rising edge sets row 1 (`row_o[0]`). At each later rising edge, every stored 1 moves from row k to row k+1.
- R3: With `dir_up`=0, a 1 on `hi_pin_i` at a rising edge sets row 263 (`row_o[262]`). At each later rising edge, every stored 1 moves from row k to row k-1.
- R4: A new start pulse can enter at the same edge on which earlier pulses move, so several pulses travel through the chain at once, each keeping its spacing.
- R5: With `full_mode`=0, rows 129 to 135 (`row_o[134:128]`) stay 0. A pulse goes from row 128 straight to row 136 going up, and from row 136 straight to row 128 going down. With `full_mode`=1, all 263 rows are in the path.
- R6: While `blank`=1, all `row_o` bits are 0. The chain keeps shifting, and once `blank` returns to 0 the rows show the current stage contents.
- R7: The cascade output carries row 263 when `dir_up`=1 and row 1 when `dir_up`=0. It changes only on the falling edge of `clk`, half a period after the rising edge that loaded that row.
- R8: With `dir_up`=1, `hi_pin_oe`=1 and `lo_pin_oe`=0. With `dir_up`=0, `lo_pin_oe`=1 and `hi_pin_oe`=0. Both `lo_pin_o` and `hi_pin_o` carry the cascade value.
- R9: The end pin currently acting as cascade output is ignored as an input. A 1 on `hi_pin_i` with `dir_up`=1, or on `lo_pin_i` with `dir_up`=0, loads no stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; stages on rising edge, cascade on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | 1: scan row 1 to 263; 0: scan row 263 to 1 |
| full_mode | input | 1 | 1: 263 rows; 0: 256 rows with rows 129-135 skipped |
| blank | input | 1 | 1 forces all row outputs inactive |
| lo_pin_i | input | 1 | Row-1 end pin, input side |
| lo_pin_o | output | 1 | Row-1 end pin, output side (cascade) |
| lo_pin_oe | output | 1 | Row-1 end pin output enable |
| hi_pin_i | input | 1 | Row-263 end pin, input side |
| hi_pin_o | output | 1 | Row-263 end pin, output side (cascade) |
| hi_pin_oe | output | 1 | Row-263 end pin output enable |
| row_o | output | NROWS | Row select outputs, bit k is row k+1 |

## Verification
A pulse presented before rising edge t shows on its row right after that edge. It reaches row n (full scan) after edge t+n-1, and the cascade output follows at the next falling edge. The bench changes inputs and samples 2 ns after each falling edge, so row outputs and the retimed cascade are both settled on the same edge's result. One extra sample is taken just after the rising edge that loads the last row, to confirm the cascade has not yet moved. Expected row positions come from a bench-side ordering function over step count, direction and mode, with the seven-row skip applied by offset.

// File: rtl/gs_pkg.sv
package gs_pkg;
  // Zero-based index helpers for the skipped band
  function automatic int band_first_idx(input int first_row);
    return first_row - 1;
  endfunction
  function automatic int band_last_idx(input int first_row, input int len);
    return first_row + len - 2;
  endfunction
endpackage

// File: rtl/gs_shift_chain.sv
module gs_shift_chain #(
  parameter int NROWS      = 263,
  parameter int BAND_FIRST = 129,
  parameter int BAND_LEN   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_up,
  input  logic             full_mode,
  input  logic             start_in,
  output logic [NROWS-1:0] stage_o
);
  import gs_pkg::*;

  localparam int B0  = band_first_idx(BAND_FIRST);
  localparam int B1  = band_last_idx(BAND_FIRST, BAND_LEN);
  localparam int BEF = B0 - 1;
  localparam int AFT = B1 + 1;

  logic [NROWS-1:0] stage_q;
  logic [NROWS-1:0] stage_d;

  for (genvar i = 0; i < NROWS; i++) begin : g_st
    logic up_src;
    logic dn_src;
    if (i == 0) begin : g_up_in
      assign up_src = start_in;
    end else if (i == AFT) begin : g_up_jump
      assign up_src = full_mode ? stage_q[i-1] : stage_q[BEF];
    end else begin : g_up_nb
      assign up_src = stage_q[i-1];
    end
    if (i == NROWS-1) begin : g_dn_in
      assign dn_src = start_in;
    end else if (i == BEF) begin : g_dn_jump
      assign dn_src = full_mode ? stage_q[i+1] : stage_q[AFT];
    end else begin : g_dn_nb
      assign dn_src = stage_q[i+1];
    end
    if (i >= B0 && i <= B1) begin : g_band
      assign stage_d[i] = full_mode & (dir_up ? up_src : dn_src);
    end else begin : g_norm
      assign stage_d[i] = dir_up ? up_src : dn_src;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_d;
  end

  assign stage_o = stage_q;

  logic exit_bit;
  assign exit_bit = dir_up ? stage_q[NROWS-1] : stage_q[0];

  assert_entry_up_R2: assert property (@(posedge clk) disable iff (rst)
    (dir_up && start_in) |=> stage_q[0]);

  assert_entry_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!dir_up && start_in) |=> stage_q[NROWS-1]);

  assert_pulse_count_R2: assert property (@(posedge clk) disable iff (rst)
    (full_mode && !start_in && !exit_bit) |=>
      ($countones(stage_q) == $past($countones(stage_q))));

  assert_band_empty_R5: assert property (@(posedge clk) disable iff (rst)
    !full_mode |=> (stage_q[B1:B0] == '0));
endmodule

// File: rtl/gs_cascade_out.sv
module gs_cascade_out (
  input  logic clk,
  input  logic rst,
  input  logic dir_up,
  input  logic stage_first,
  input  logic stage_last,
  output logic casc_o
);
  logic casc_q;

  always_ff @(negedge clk) begin
    if (rst) casc_q <= 1'b0;
    else     casc_q <= dir_up ? stage_last : stage_first;
  end

  assign casc_o = casc_q;

  assert_casc_follows_R7: assert property (@(negedge clk) disable iff (rst)
    (dir_up ? stage_last : stage_first) |=> casc_q);
endmodule

// File: rtl/gs_row_mask.sv
module gs_row_mask #(
  parameter int NROWS = 263
) (
  input  logic [NROWS-1:0] stage_i,
  input  logic             blank,
  output logic [NROWS-1:0] row_o
);
  always_comb row_o = blank ? '0 : stage_i;
endmodule

// File: rtl/gate_scan_chain.sv
module gate_scan_chain #(
  parameter int NROWS      = 263,
  parameter int BAND_FIRST = 129,
  parameter int BAND_LEN   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_up,
  input  logic             full_mode,
  input  logic             blank,
  input  logic             lo_pin_i,
  output logic             lo_pin_o,
  output logic             lo_pin_oe,
  input  logic             hi_pin_i,
  output logic             hi_pin_o,
  output logic             hi_pin_oe,
  output logic [NROWS-1:0] row_o
);
  logic             start_in;
  logic [NROWS-1:0] stage;
  logic             casc;

  assign start_in = dir_up ? lo_pin_i : hi_pin_i;

  gs_shift_chain #(
    .NROWS(NROWS), .BAND_FIRST(BAND_FIRST), .BAND_LEN(BAND_LEN)
  ) u_chain (
    .clk(clk), .rst(rst), .dir_up(dir_up), .full_mode(full_mode),
    .start_in(start_in), .stage_o(stage)
  );

  gs_cascade_out u_casc (
    .clk(clk), .rst(rst), .dir_up(dir_up),
    .stage_first(stage[0]), .stage_last(stage[NROWS-1]), .casc_o(casc)
  );

  gs_row_mask #(.NROWS(NROWS)) u_mask (
    .stage_i(stage), .blank(blank), .row_o(row_o)
  );

  assign lo_pin_o  = casc;
  assign hi_pin_o  = casc;
  assign lo_pin_oe = ~dir_up;
  assign hi_pin_oe = dir_up;
endmodule

// File: tb/tb_gate_scan_chain.sv
`timescale 1ns/1ps
module tb_gate_scan_chain;
  localparam int N = 263;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_up = 1'b1, full_mode = 1'b1, blank = 1'b0;
  logic lo_pin_i = 1'b0, hi_pin_i = 1'b0;
  logic lo_pin_o, lo_pin_oe, hi_pin_o, hi_pin_oe;
  logic [N-1:0] row_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gate_scan_chain dut (
    .clk(clk), .rst(rst), .dir_up(dir_up), .full_mode(full_mode),
    .blank(blank), .lo_pin_i(lo_pin_i), .lo_pin_o(lo_pin_o),
    .lo_pin_oe(lo_pin_oe), .hi_pin_i(hi_pin_i), .hi_pin_o(hi_pin_o),
    .hi_pin_oe(hi_pin_oe), .row_o(row_o)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected row (1-based) after edge t of a single pulse; 0 when gone
  function automatic int exp_row(input bit up, input bit full, input int t);
    int r;
    if (up) begin
      r = t + 1;
      if (!full && r > 128) r += 7;
      if (r > N) r = 0;
    end else begin
      r = N - t;
      if (!full && r < 136) r -= 7;
      if (r < 1) r = 0;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] onehot(input int r);
    logic [N-1:0] v = '0;
    if (r > 0) v[r-1] = 1'b1;
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; lo_pin_i = 0; hi_pin_i = 0; blank = 0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    dir_up = 1; full_mode = 1;
    do_reset();
    chk(row_o == '0, "R1 rows clear", row_o, '0);
    chk(lo_pin_o == 0 && hi_pin_o == 0, "R1 cascade clear", {lo_pin_o, hi_pin_o}, '0);
    lo_pin_i = 1; step(); lo_pin_i = 0; step();
    rst = 1; step(); rst = 0;
    chk(row_o == '0, "R1 mid-scan reset", row_o, '0);
  endtask

  task automatic t_pins();
    dir_up = 1; #1;
    chk(hi_pin_oe == 1 && lo_pin_oe == 0, "R8 up enables", {lo_pin_oe, hi_pin_oe}, 2'b01);
    dir_up = 0; #1;
    chk(lo_pin_oe == 1 && hi_pin_oe == 0, "R8 down enables", {lo_pin_oe, hi_pin_oe}, 2'b10);
  endtask

  task automatic t_scan(input bit up, input bit full);
    int last_t;
    int endr;
    logic [N-1:0] ev;
    dir_up = up; full_mode = full;
    do_reset();
    last_t = full ? N - 1 : N - 8;
    endr = up ? N : 1;
    if (up) lo_pin_i = 1; else hi_pin_i = 1;
    for (int t = 0; t < last_t + 3; t++) begin
      @(posedge clk); #1;
      if (t == last_t)
        chk((up ? hi_pin_o : lo_pin_o) == 0, "R7 cascade waits for falling edge",
            {N{1'b0}} | (up ? hi_pin_o : lo_pin_o), '0);
      @(negedge clk); #2;
      lo_pin_i = 0; hi_pin_i = 0;
      ev = onehot(exp_row(up, full, t));
      chk(row_o == ev, up ? (full ? "R2 up scan" : "R5 up skip")
                          : (full ? "R3 down scan" : "R5 down skip"), row_o, ev);
      chk((up ? hi_pin_o : lo_pin_o) == (exp_row(up, full, t) == endr),
          "R7 cascade", {N{1'b0}} | (up ? hi_pin_o : lo_pin_o),
          {N{1'b0}} | (exp_row(up, full, t) == endr));
      chk(lo_pin_o == hi_pin_o, "R8 both pins carry cascade",
          {N{1'b0}} | lo_pin_o, {N{1'b0}} | hi_pin_o);
    end
  endtask

  task automatic t_multi();
    logic [N-1:0] ev;
    dir_up = 1; full_mode = 1;
    do_reset();
    for (int t = 0; t < 10; t++) begin
      lo_pin_i = (t == 0 || t == 3);
      step();
      ev = onehot(t + 1);
      if (t >= 3) ev = ev | onehot(t - 2);
      chk(row_o == ev, "R4 two pulses", row_o, ev);
    end
    lo_pin_i = 0;
  endtask

  task automatic t_blank();
    dir_up = 1; full_mode = 1;
    do_reset();
    lo_pin_i = 1; step(); lo_pin_i = 0;
    for (int t = 1; t < 5; t++) step();
    blank = 1; #1;
    chk(row_o == '0, "R6 blank masks rows", row_o, '0);
    for (int t = 5; t < 8; t++) begin
      step();
      chk(row_o == '0, "R6 blank holds", row_o, '0);
    end
    blank = 0; #1;
    chk(row_o == onehot(8), "R6 shifting continued", row_o, onehot(8));
  endtask

  task automatic t_ignore();
    dir_up = 1; full_mode = 1;
    do_reset();
    hi_pin_i = 1;
    for (int t = 0; t < 3; t++) begin
      step();
      chk(row_o == '0, "R9 hi pin ignored when up", row_o, '0);
    end
    hi_pin_i = 0;
    dir_up = 0;
    lo_pin_i = 1;
    for (int t = 0; t < 3; t++) begin
      step();
      chk(row_o == '0, "R9 lo pin ignored when down", row_o, '0);
    end
    lo_pin_i = 0;
  endtask

  initial begin
    t_reset();
    t_pins();
    t_scan(1, 1);
    t_scan(0, 1);
    t_scan(1, 0);
    t_scan(0, 0);
    t_multi();
    t_blank();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule